// File: doc/BRIEF.md
# CAN Overload Condition Detector

This block sits beside a CAN protocol engine and decides, bit by bit, whether the bus has shown one of the conditions that oblige the node to start an overload frame. On every bit-sample strobe the engine presents the sampled bus level (0 is dominant), a code for the field it is in, the 1-based position of the bit within that field, and whether the current frame is one the node is receiving. When a dominant level is seen at one of the trigger positions, the block raises a single-clock overload request. The engine then builds and drives the overload flag. That work is outside this block.

There are three trigger positions. The first is either of the first two bits of intermission. The second is the seventh and last bit of end-of-frame, and it counts only while a frame is being received. The third is the eighth and last bit of an error delimiter or an overload delimiter. A dominant third intermission bit is a start of frame and does not trigger. A recessive bit never triggers.

Top module: `can_ovl_detect`

## Requirements
- R1: While reset is high, and afterwards until a qualifying strobe is seen, `ovl_req` is 0.
- R2: A strobe with `bus_level`=0, `field_code`=2 (intermission) and `bit_index` 1 or 2 makes `ovl_req` 1 in the clock after the strobe.
- R3: A strobe with `bus_level`=0, `field_code`=1 (end-of-frame) and `bit_index`=7 makes `ovl_req` 1 in the next clock when `rx_frame`=1, and leaves it 0 when `rx_frame`=0.
- R4: A strobe with `bus_level`=0, `field_code` 3 (error delimiter) or 4 (overload delimiter) and `bit_index`=8 makes `ovl_req` 1 in the next clock, whatever `rx_frame` is.
- R5: A dominant strobe at `field_code`=2 with `bit_index`=3 does not raise `ovl_req`.
- R6: Inputs are evaluated only in cycles with `bit_strobe`=1. `ovl_req` is 1 for exactly the one clock that follows a qualifying strobe.
- R7: A strobe with `bus_level`=1 never raises `ovl_req`, at any field or position.
- R8: No other combination raises `ovl_req`. This covers `field_code` 0 and 5 to 7 (other), end-of-frame bits 1 to 6, delimiter bits 1 to 7, and intermission bits 0 and 4 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_strobe | input | 1 | One-clock strobe marking a sampled bus bit |
| bus_level | input | 1 | Sampled bus level, 0 = dominant |
| field_code | input | 3 | Current field: 0 other, 1 end-of-frame, 2 intermission, 3 error delimiter, 4 overload delimiter |
| bit_index | input | IDX_W (4) | 1-based bit position within the field |
| rx_frame | input | 1 | 1 while the current frame is being received |
| ovl_req | output | 1 | One-clock overload request |

## Verification
The decision is combinational and the request comes from one output register. A request is therefore due in the clock that follows the strobed cycle, and it clears one clock after that. The bench drives each input set on a falling edge. It checks `ovl_req` just after the next rising edge for the expected pulse, then drops the strobe and checks just after the following rising edge that the pulse has ended. Every code, index, level and receive-flag combination is swept this way. A second sweep repeats the dominant patterns with the strobe low and expects no request one clock later.

// File: rtl/can_ovl_pkg.sv
package can_ovl_pkg;
  typedef enum logic [2:0] {
    FLD_OTHER    = 3'd0,
    FLD_EOF      = 3'd1,
    FLD_INTER    = 3'd2,
    FLD_ERRDELIM = 3'd3,
    FLD_OVLDELIM = 3'd4
  } fld_e;
endpackage

// File: rtl/can_ovl_pos_decode.sv
module can_ovl_pos_decode
  import can_ovl_pkg::*;
#(
  parameter int IDX_W       = 4,
  parameter int EOF_LEN     = 7,
  parameter int DELIM_LEN   = 8,
  parameter int INTER_WATCH = 2
) (
  input  logic [2:0]       field_code,
  input  logic [IDX_W-1:0] bit_index,
  input  logic             rx_frame,
  output logic             trig_pos
);
  localparam logic [IDX_W-1:0] EOF_LAST   = IDX_W'(EOF_LEN);
  localparam logic [IDX_W-1:0] DELIM_LAST = IDX_W'(DELIM_LEN);

  logic [INTER_WATCH-1:0] inter_slot;
  logic                   in_inter, eof_hit, delim_hit;

  for (genvar k = 0; k < INTER_WATCH; k++) begin : g_inter
    assign inter_slot[k] = (bit_index == IDX_W'(k + 1));
  end

  always_comb begin
    in_inter  = (field_code == FLD_INTER) && (|inter_slot);
    eof_hit   = (field_code == FLD_EOF) && (bit_index == EOF_LAST) && rx_frame;
    delim_hit = ((field_code == FLD_ERRDELIM) || (field_code == FLD_OVLDELIM))
                && (bit_index == DELIM_LAST);
    trig_pos  = in_inter || eof_hit || delim_hit;
  end
endmodule

// File: rtl/can_ovl_pulse.sv
module can_ovl_pulse (
  input  logic clk,
  input  logic rst,
  input  logic bit_strobe,
  input  logic bus_level,
  input  logic trig_pos,
  output logic ovl_req
);
  always_ff @(posedge clk) begin
    if (rst) ovl_req <= 1'b0;
    else     ovl_req <= bit_strobe && !bus_level && trig_pos;
  end
endmodule

// File: rtl/can_ovl_detect.sv
module can_ovl_detect #(
  parameter int IDX_W       = 4,
  parameter int EOF_LEN     = 7,
  parameter int DELIM_LEN   = 8,
  parameter int INTER_WATCH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_strobe,
  input  logic             bus_level,
  input  logic [2:0]       field_code,
  input  logic [IDX_W-1:0] bit_index,
  input  logic             rx_frame,
  output logic             ovl_req
);
  logic trig_pos;

  can_ovl_pos_decode #(
    .IDX_W(IDX_W), .EOF_LEN(EOF_LEN), .DELIM_LEN(DELIM_LEN), .INTER_WATCH(INTER_WATCH)
  ) u_dec (
    .field_code(field_code),
    .bit_index (bit_index),
    .rx_frame  (rx_frame),
    .trig_pos  (trig_pos)
  );

  can_ovl_pulse u_pulse (
    .clk       (clk),
    .rst       (rst),
    .bit_strobe(bit_strobe),
    .bus_level (bus_level),
    .trig_pos  (trig_pos),
    .ovl_req   (ovl_req)
  );
endmodule

// File: rtl/can_ovl_detect_chk.sv
module can_ovl_detect_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             bit_strobe,
  input logic             bus_level,
  input logic [2:0]       field_code,
  input logic [IDX_W-1:0] bit_index,
  input logic             rx_frame,
  input logic             ovl_req
);
  p_strobe_only_r6: assert property (@(posedge clk) disable iff (rst)
    ovl_req |-> $past(bit_strobe));

  p_recessive_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    ovl_req |-> !$past(bus_level));

  p_eof_rx_only_r3: assert property (@(posedge clk) disable iff (rst)
    (ovl_req && $past(field_code) == 3'd1) |-> $past(rx_frame));

  p_inter_third_r5: assert property (@(posedge clk) disable iff (rst)
    (bit_strobe && field_code == 3'd2 && bit_index == IDX_W'(3)) |=> !ovl_req);

  p_inter_trigger_r2: assert property (@(posedge clk) disable iff (rst)
    (bit_strobe && !bus_level && field_code == 3'd2
     && (bit_index == IDX_W'(1) || bit_index == IDX_W'(2))) |=> ovl_req);

  p_delim_trigger_r4: assert property (@(posedge clk) disable iff (rst)
    (bit_strobe && !bus_level && (field_code == 3'd3 || field_code == 3'd4)
     && bit_index == IDX_W'(8)) |=> ovl_req);

  p_other_field_r8: assert property (@(posedge clk) disable iff (rst)
    (ovl_req) |-> ($past(field_code) >= 3'd1 && $past(field_code) <= 3'd4));
endmodule

bind can_ovl_detect can_ovl_detect_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .bit_strobe(bit_strobe), .bus_level(bus_level),
  .field_code(field_code), .bit_index(bit_index), .rx_frame(rx_frame),
  .ovl_req(ovl_req)
);

// File: tb/tb_can_ovl_detect.sv
`timescale 1ns/1ps
module tb_can_ovl_detect;
  localparam int IDX_W = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             bit_strobe = 1'b0;
  logic             bus_level = 1'b1;
  logic [2:0]       field_code = 3'd0;
  logic [IDX_W-1:0] bit_index = '0;
  logic             rx_frame = 1'b0;
  logic             ovl_req;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  can_ovl_detect #(.IDX_W(IDX_W)) dut (
    .clk(clk), .rst(rst), .bit_strobe(bit_strobe), .bus_level(bus_level),
    .field_code(field_code), .bit_index(bit_index), .rx_frame(rx_frame),
    .ovl_req(ovl_req)
  );

  function automatic bit expect_req(int f, int idx, int lvl, int rx);
    if (lvl != 0) return 1'b0;
    if (f == 2 && (idx == 1 || idx == 2)) return 1'b1;
    if (f == 1 && idx == 7 && rx == 1) return 1'b1;
    if ((f == 3 || f == 4) && idx == 8) return 1'b1;
    return 1'b0;
  endfunction

  function automatic string req_tag(int f, int idx, int lvl);
    if (lvl != 0) return "R7";
    if (f == 2 && (idx == 1 || idx == 2)) return "R2";
    if (f == 2 && idx == 3) return "R5";
    if (f == 1 && idx == 7) return "R3";
    if ((f == 3 || f == 4) && idx == 8) return "R4";
    return "R8";
  endfunction

  task automatic check(string tag, bit act, bit exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: ovl_req=%0b expected %0b (f=%0d idx=%0d lvl=%0b rx=%0b stb=%0b)",
               tag, act, exp, field_code, bit_index, bus_level, rx_frame, bit_strobe);
    end
  endtask

  task automatic apply(int f, int idx, int lvl, int rx, bit stb);
    @(negedge clk);
    field_code = 3'(f); bit_index = IDX_W'(idx); bus_level = lvl[0];
    rx_frame = rx[0]; bit_strobe = stb;
    @(posedge clk); #1;
    if (stb) check(req_tag(f, idx, lvl), ovl_req, expect_req(f, idx, lvl, rx));
    else     check("R6", ovl_req, 1'b0);
    @(negedge clk);
    bit_strobe = 1'b0;
    @(posedge clk); #1;
    check("R6", ovl_req, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1", ovl_req, 1'b0);
    bit_strobe = 1'b1; bus_level = 1'b0; field_code = 3'd2; bit_index = IDX_W'(1);
    @(posedge clk); #1 check("R1", ovl_req, 1'b0);
    @(negedge clk);
    bit_strobe = 1'b0; rst = 1'b0;
    @(posedge clk); #1 check("R1", ovl_req, 1'b0);

    for (int f = 0; f < 8; f++)
      for (int idx = 0; idx < 16; idx++)
        for (int lvl = 0; lvl < 2; lvl++)
          for (int rx = 0; rx < 2; rx++)
            apply(f, idx, lvl, rx, 1'b1);

    for (int f = 0; f < 8; f++)
      for (int idx = 0; idx < 16; idx++)
        apply(f, idx, 0, 1, 1'b0);

    // back-to-back strobes on intermission bits 1 and 2, then bit 3 (R2, R5)
    @(negedge clk);
    field_code = 3'd2; bus_level = 1'b0; bit_strobe = 1'b1; bit_index = IDX_W'(1);
    @(negedge clk); bit_index = IDX_W'(2);
    #1 check("R2", ovl_req, 1'b1);
    @(negedge clk); bit_index = IDX_W'(3);
    #1 check("R2", ovl_req, 1'b1);
    @(negedge clk); bit_strobe = 1'b0;
    #1 check("R5", ovl_req, 1'b0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not finish");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule